// File: doc/BRIEF.md
# Configurable Serial Port Word Shifter

This block is the data path of one synchronous serial channel. It takes parallel words from a valid/ready input, frames them and shifts them out on a serial data line. In the same frame it shifts the serial input back in and presents each finished word on a parallel output with a one-cycle valid pulse. A single 20-bit control word sets the word length, the bit order, how received words are widened to 32 bits, optional 16-to-32-bit packing, the framing style, the clock source and the internal clock divisor.

Each frame has one lead bit period followed by the data bits. In framed serial mode the frame line is high during the lead period. In stereo sample-pair mode the frame line is a channel-select level that changes at the start of every frame: the first word after enabling is the left channel (level low), and the lead period gives the usual one-bit delay before the first data bit. The serial clock comes either from a divider on the system clock or from an external pin, which is synchronised to the system clock. The two companding type codes are accepted and handled like zero fill.

Top module: `sport_word_shifter`

## Requirements
- R1: Control bit 0 enables the channel. After reset the channel is disabled, `tx_ready`, `rx_valid`, `sd_o` and `fs_o` are low, and `tx_ready` stays low while the channel is disabled.
- R2: Control bits 8:4 hold the word length minus one. A value below the mode minimum is raised to that minimum: 3 bits in framed mode, 8 bits in stereo mode (bit 11 set). The maximum is 32 bits.
- R3: Control bits 2:1 equal to 00, 10 or 11 right-justify the received word and clear all bits above it.
- R4: Control bits 2:1 equal to 01 right-justify the received word and copy its top bit into all bits above it.
- R5: Control bit 3 set sends and receives the least significant bit first; clear sends the most significant bit first. In stereo mode the bit is ignored and the most significant bit always goes first.
- R6: Control bit 9 set packs two 16-bit serial words into one 32-bit parallel word. On transmit the lower half goes first, and on receive the first word fills the lower half.
- R7: Control bit 10 set selects the internal serial clock, whose period is 2*(D+1) system clocks, where D is control bits 19:12. Clear selects `ext_sclk_i`.
- R8: In framed mode `fs_o` is high for exactly one serial clock period before each word, and `sd_o` is low during that period. In stereo mode `fs_o` is low for the first word after enabling and changes level at the start of each later word.
- R9: While the channel is enabled, a control write with bit 0 set is ignored. A write with bit 0 clear is always accepted.
- R10: Disabling the channel aborts any word in progress. No received word comes from an aborted frame, and nothing from it leaks into later words.
- R11: `rx_valid` is a one-cycle pulse for each completed parallel word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 20 | Control word |
| ext_sclk_i | input | 1 | External serial clock |
| sd_i | input | 1 | Serial data in |
| tx_data | input | 32 | Parallel word to send |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register free |
| rx_data | output | 32 | Received, widened word |
| rx_valid | output | 1 | One-cycle received-word strobe |
| sclk_o | output | 1 | Serial clock level in use |
| fs_o | output | 1 | Frame sync / channel select |
| fs_oe | output | 1 | High when the port drives the frame line |
| sd_o | output | 1 | Serial data out |

## Verification
Two events can fall into the same cycle. A control write can arrive while a word is halfway through the shifters, and a disabling write can arrive while a frame is running. The bench provokes the first by issuing a new length with the enable bit still set while a word is queued. The word must then come back at the old length, with the upper bits zero. It provokes the second by disabling during a 32-bit frame. No word may appear, and a fresh short word sent after re-enabling must return intact. A monitor on the serial clock also records the bit order and the frame-line timing, so that bit order is judged on the wire and not only through the loopback.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = $clog2(DATA_W) + 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             stereo;
    logic             int_clk;
    logic             pack;
    logic [4:0]       len_m1;
    logic             lsb_first;
    logic [1:0]       fill;
    logic             en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             use_int,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_sclk,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] dcnt;
  logic [1:0]       sync;
  logic             tick;

  assign tick = use_int && (dcnt == div);
  assign rise = use_int ? (tick && !sclk) : (sync[1] && !sclk);
  assign fall = use_int ? (tick && sclk)  : (!sync[1] && sclk);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      dcnt <= '0;
      sync <= '0;
      sclk <= 1'b0;
    end else begin
      sync <= {sync[0], ext_sclk};
      if (use_int) begin
        if (tick) begin
          dcnt <= '0;
          sclk <= ~sclk;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end else begin
        sclk <= sync[1];
      end
    end
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              fall,
  input  logic [LEN_W-1:0]  len,
  input  logic              lsb_first,
  input  logic              pack,
  input  logic              stereo,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              active,
  output logic [LEN_W-1:0]  cnt,
  output logic              sd_o,
  output logic              fs_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] hold, tsh, word;
  logic              full, half, ws;

  assign tx_ready = run && !full;
  assign fs_o     = stereo ? ws : (active && cnt == '0);

  always_comb begin
    if (pack)
      word = half ? {{HALF_W{1'b0}}, hold[DATA_W-1:HALF_W]}
                  : {{HALF_W{1'b0}}, hold[HALF_W-1:0]};
    else
      word = hold;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hold   <= '0;
      tsh    <= '0;
      full   <= 1'b0;
      half   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      sd_o   <= 1'b0;
      ws     <= 1'b1;
    end else begin
      if (tx_valid && !full) begin
        hold <= tx_data;
        full <= 1'b1;
      end
      if (fall) begin
        if (!active || cnt == len) begin
          sd_o <= 1'b0;
          if (full) begin
            active <= 1'b1;
            cnt    <= '0;
            ws     <= ~ws;
            tsh    <= lsb_first ? word : (word << (LEN_W'(DATA_W) - len));
            if (pack && !half) begin
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              full <= 1'b0;
            end
          end else begin
            active <= 1'b0;
          end
        end else begin
          cnt  <= cnt + 1'b1;
          sd_o <= lsb_first ? tsh[0] : tsh[DATA_W-1];
          tsh  <= lsb_first ? (tsh >> 1) : (tsh << 1);
        end
      end
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              rise,
  input  logic              active,
  input  logic [LEN_W-1:0]  cnt,
  input  logic [LEN_W-1:0]  len,
  input  logic              lsb_first,
  input  logic              pack,
  input  logic              sign_fill,
  input  logic              sd_i,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] rsh, nxt, aligned, mask, filled;
  logic [HALF_W-1:0] lo;
  logic              rhalf, top;

  always_comb begin
    nxt     = lsb_first ? {sd_i, rsh[DATA_W-1:1]} : {rsh[DATA_W-2:0], sd_i};
    aligned = lsb_first ? (nxt >> (LEN_W'(DATA_W) - len)) : nxt;
    mask    = (DATA_W'(1) << len) - DATA_W'(1);
    top     = aligned[5'(len - 1'b1)];
    filled  = (sign_fill && top) ? (aligned | ~mask) : (aligned & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh      <= '0;
      lo       <= '0;
      rhalf    <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (!run) begin
      rsh      <= '0;
      rhalf    <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise && active) begin
        if (cnt == '0) begin
          rsh <= '0;
        end else begin
          rsh <= nxt;
          if (cnt == len) begin
            if (!pack) begin
              rx_data  <= filled;
              rx_valid <= 1'b1;
            end else if (!rhalf) begin
              lo    <= filled[HALF_W-1:0];
              rhalf <= 1'b1;
            end else begin
              rx_data  <= {filled[HALF_W-1:0], lo};
              rx_valid <= 1'b1;
              rhalf    <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sport_word_shifter.sv
module sport_word_shifter
  import sport_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic          ext_sclk_i,
  input  logic          sd_i,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          sclk_o,
  output logic          fs_o,
  output logic          fs_oe,
  output logic          sd_o
);
  ctrl_t         ctrl_q, ctrl_w;
  logic [4:0]    min_m1, len_m1_eff;
  logic [LW-1:0] len_eff, cnt;
  logic          rise, fall, active, lsb_eff;

  assign ctrl_w = ctrl_t'(ctrl_wdata);

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (ctrl_we && (!ctrl_q.en || !ctrl_w.en))
      ctrl_q <= ctrl_w;
  end

  assign min_m1     = ctrl_q.stereo ? 5'd7 : 5'd2;
  assign len_m1_eff = (ctrl_q.len_m1 < min_m1) ? min_m1 : ctrl_q.len_m1;
  assign len_eff    = LW'(len_m1_eff) + 1'b1;
  assign lsb_eff    = ctrl_q.lsb_first && !ctrl_q.stereo;
  assign fs_oe      = !ctrl_q.stereo || ctrl_q.int_clk;

  sport_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .use_int(ctrl_q.int_clk),
    .div(ctrl_q.div), .ext_sclk(ext_sclk_i),
    .sclk(sclk_o), .rise(rise), .fall(fall)
  );

  sport_tx #(.DATA_W(DW), .LEN_W(LW)) u_tx (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .fall(fall), .len(len_eff),
    .lsb_first(lsb_eff), .pack(ctrl_q.pack), .stereo(ctrl_q.stereo),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .active(active), .cnt(cnt), .sd_o(sd_o), .fs_o(fs_o)
  );

  sport_rx #(.DATA_W(DW), .LEN_W(LW)) u_rx (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .rise(rise), .active(active),
    .cnt(cnt), .len(len_eff), .lsb_first(lsb_eff), .pack(ctrl_q.pack),
    .sign_fill(ctrl_q.fill == 2'b01), .sd_i(sd_i),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/sport_word_shifter_chk.sv
module sport_word_shifter_chk
  import sport_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input ctrl_t             ctrl,
  input logic              ctrl_we,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic [LEN_W-1:0]  len,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              fs_o,
  input logic              sd_o
);
  logic [DATA_W-1:0] above, from_top;
  assign above    = rx_data >> len;
  assign from_top = rx_data >> (len - 1'b1);

  AST_NO_READY_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |-> !tx_ready); // R1

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl.en && ctrl_wdata[0]) |=> $stable(ctrl)); // R9

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ctrl.en && ctrl.fill != 2'b01 && !ctrl.pack && len != LEN_W'(DATA_W))
      |-> (above == '0)); // R3

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ctrl.en && ctrl.fill == 2'b01 && !ctrl.pack && len != LEN_W'(DATA_W))
      |-> (from_top == '0 || from_top == ({DATA_W{1'b1}} >> (len - 1'b1)))); // R4

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R11

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && !ctrl.stereo && fs_o) |-> !sd_o); // R8
endmodule

bind sport_word_shifter sport_word_shifter_chk u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_q), .ctrl_we(ctrl_we),
  .ctrl_wdata(ctrl_wdata), .len(len_eff), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .fs_o(fs_o), .sd_o(sd_o)
);

// File: tb/sport_word_shifter_tb.sv
`timescale 1ns/1ps
module sport_word_shifter_tb;
  logic        clk = 1'b0, rst = 1'b1, ctrl_we = 1'b0, ext_sclk = 1'b0;
  logic [19:0] ctrl_wdata = '0;
  logic [31:0] tx_data = '0, rx_data;
  logic        tx_valid = 1'b0, tx_ready, rx_valid, sclk_o, fs_o, fs_oe, sd_o;
  int total = 0, fails = 0;

  always #2 clk = ~clk;
  always #20 ext_sclk = ~ext_sclk;

  sport_word_shifter u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ext_sclk_i(ext_sclk), .sd_i(sd_o), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk_o(sclk_o), .fs_o(fs_o), .fs_oe(fs_oe), .sd_o(sd_o)
  );

  // serial line monitor
  logic mon [32];
  int   idx = 0, fs_seen = 0;
  logic mon_stereo = 1'b0, prev_fs = 1'b0;
  always @(posedge sclk_o) begin
    logic lead;
    lead = mon_stereo ? (fs_o != prev_fs) : fs_o;
    prev_fs = fs_o;
    if (lead) begin
      idx = 0;
      fs_seen++;
    end else if (idx < 32) begin
      mon[idx] = sd_o;
      idx++;
    end
  end

  function automatic logic [19:0] cfg(bit st, bit ic, bit pk, int lm1, bit lsb, int fl, int dv);
    return {dv[7:0], st, ic, pk, lm1[4:0], lsb, fl[1:0], 1'b1};
  endfunction

  localparam int NV = 12;
  localparam logic [83:0] VEC [NV] = '{
    {cfg(0,1,0,7,0,0,1),  32'h0000_00A5, 32'h0000_00A5},  // R3 R2
    {cfg(0,1,0,7,0,1,1),  32'h0000_00A5, 32'hFFFF_FFA5},  // R4
    {cfg(0,1,0,7,0,1,1),  32'h0000_005A, 32'h0000_005A},  // R4
    {cfg(0,1,0,7,1,0,1),  32'h1234_56C3, 32'h0000_00C3},  // R5 R3
    {cfg(0,1,0,31,0,0,1), 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2
    {cfg(0,1,0,11,1,1,1), 32'h0000_0800, 32'hFFFF_F800},  // R4
    {cfg(0,1,0,0,0,1,1),  32'h0000_000D, 32'hFFFF_FFFD},  // R2 min 3
    {cfg(1,1,0,2,1,0,1),  32'h0000_01FF, 32'h0000_00FF},  // R2 min 8
    {cfg(1,1,0,15,0,1,1), 32'h0000_8001, 32'hFFFF_8001},  // R4 stereo
    {cfg(0,1,1,15,0,0,1), 32'h89AB_CDEF, 32'h89AB_CDEF},  // R6
    {cfg(0,0,0,7,0,0,0),  32'h0000_003C, 32'h0000_003C},  // R7 external
    {cfg(0,1,0,7,0,2,1),  32'h0000_00A5, 32'h0000_00A5}   // R3 code 10
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [19:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic setup(logic [19:0] v);
    wr_ctrl('0);
    wr_ctrl(v);
    mon_stereo = v[11];
    fs_seen = 0;
  endtask

  task automatic send(logic [31:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(output logic [31:0] got, output bit seen, input int lim);
    seen = 0; got = 'x;
    for (int k = 0; k < lim && !seen; k++) begin
      @(negedge clk);
      if (rx_valid) begin seen = 1; got = rx_data; end
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got;
    bit seen;
    realtime t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset tx_ready", {31'b0, tx_ready}, 32'd0);
    check("R1 reset rx_valid", {31'b0, rx_valid}, 32'd0);
    check("R1 reset sd/fs", {30'b0, sd_o, fs_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][83:64]);
      send(VEC[i][63:32]);
      wait_rx(got, seen, 5000);
      check($sformatf("R2-vector %0d word", i), got, VEC[i][31:0]);
    end

    // R5 and R8: MSB first on the wire, one sync period per word
    setup(cfg(0,1,0,7,0,0,1));
    send(32'h01);
    wait_rx(got, seen, 5000);
    check("R5 msb-first first bit/last bit", {30'b0, mon[0], mon[7]}, 32'b01);
    check("R8 data bits after sync", idx, 8);
    check("R8 sync periods per word", fs_seen, 1);

    setup(cfg(0,1,0,7,1,0,1));
    send(32'h01);
    wait_rx(got, seen, 5000);
    check("R5 lsb-first first bit/last bit", {30'b0, mon[0], mon[7]}, 32'b10);

    // R5: bit order ignored in stereo mode; R8 channel select
    setup(cfg(1,1,0,7,1,0,1));
    send(32'h01);
    wait_rx(got, seen, 5000);
    check("R5 stereo ignores lsb-first", {30'b0, mon[0], mon[7]}, 32'b01);
    check("R8 first stereo word level", {31'b0, fs_o}, 32'd0);
    send(32'h22);
    wait_rx(got, seen, 5000);
    check("R8 second stereo word level", {31'b0, fs_o}, 32'd1);
    check("R8 second stereo word data", got, 32'h22);

    // R7: divisor 3 -> 8 system clocks of 4 ns
    setup(cfg(0,1,0,7,0,0,3));
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o);
    check("R7 internal clock period ns", int'($realtime - t0), 32);

    // R9: enabled write with enable set is ignored
    setup(cfg(0,1,0,7,0,0,1));
    wr_ctrl(cfg(0,1,0,31,0,0,1));
    send(32'hA5A5_A5A5);
    wait_rx(got, seen, 5000);
    check("R9 locked length kept", got, 32'h0000_00A5);

    // R10: abort mid-word
    setup(cfg(0,1,0,31,0,0,10));
    send(32'hFFFF_FFFF);
    repeat (200) @(negedge clk);
    wr_ctrl('0);
    check("R1 tx_ready while disabled", {31'b0, tx_ready}, 32'd0);
    wait_rx(got, seen, 1500);
    check("R10 no word from aborted frame", {31'b0, seen}, 32'd0);
    setup(cfg(0,1,0,7,0,1,1));
    send(32'h3C);
    wait_rx(got, seen, 5000);
    check("R10 clean word after abort", got, 32'h0000_003C);

    // R11: single pulse per word, none after
    send(32'h11);
    wait_rx(got, seen, 5000);
    @(negedge clk);
    check("R11 rx_valid one cycle", {31'b0, rx_valid}, 32'd0);

    summary();
    $finish;
  end
endmodule